// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is a synthesizable model of a parallel NOR flash part that is driven by the two-cycle unlock command set. It sits on a plain synchronous bus: a byte address, a 32-bit write word, write and read strobes, an access size and a byte-order select. It holds a small byte array, divided into equal power-of-two sectors, which comes out of reset fully erased (every byte 0xFF).

Every change to the array is gated by a strict sequence of bus writes. Two unlock writes come first, then a command write. A program then takes one data write, which can only clear bits. An erase needs a second unlock pair and then an opcode that erases either the whole array or a single sector. Erases are not instantaneous. A cycle counter holds the part busy for a length set by a parameter, and a status byte replaces array data on reads until the counter expires. A query mode returns a small identification string. A read-only input lets every sequence run without touching the array.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the array holds 0xFF in every byte, `busy_o` is low, `rdata_o` is zero and the part is in read-array mode.
- R2: A sequence starts only with data 0xAA (in `wdata_i[7:0]`) written at sector offset `UNLOCK_A` (address bits below the sector size). Any other write in read-array mode starts nothing.
- R3: The write after the first unlock must be 0x55 at sector offset `UNLOCK_B`. Otherwise the part returns to read-array mode.
- R4: The third write must be at sector offset `UNLOCK_A`. Data 0xA0 arms a program and 0x80 arms erase setup. Any other address or data returns the part to read-array mode.
- R5: The write after 0xA0 programs 1, 2 or 4 bytes (`size_i` 0, 1, 2/3) from `addr_i` upward. Each stored byte becomes the old byte ANDed with its data byte. Byte addresses wrap modulo the array size.
- R6: While a program is busy (`PROG_CYC` cycles), every read returns the status byte in `rdata_o[7:0]`, with upper bits zero. Status bit 7 is the inverse of `wdata_i[7]` of the data write, and the other status bits are zero.
- R7: After 0x80, an erase opcode is accepted only after a second 0xAA/`UNLOCK_A`, 0x55/`UNLOCK_B` pair. A wrong write returns the part to read-array mode with no erase.
- R8: Opcode 0x10 erases the whole array to 0xFF, but only when written at sector offset `UNLOCK_A`. At any other offset the part returns to read-array mode and nothing is erased.
- R9: Opcode 0x30 sets every byte of the sector holding `addr_i` to 0xFF and leaves all other sectors unchanged.
- R10: `busy_o` rises on the cycle after an erase opcode is accepted. It stays high for exactly `CHIP_ERASE_CYC` cycles (chip) or `SECT_ERASE_CYC` cycles (sector), and reads return status 0x00 during that time. When it falls the part is back in read-array mode.
- R11: Bus writes made while `busy_o` is high are ignored and change neither the array nor the sequence state.
- R12: With `wp_i` high, program and erase sequences still set the status and the busy time, but the array is unchanged.
- R13: In read-array mode, data 0x98 written at sector offset 0x55 enters query mode. Reads then return 0x51, 0x52, 0x59 at sector offsets 0x10, 0x11, 0x12 and 0x00 elsewhere, in `rdata_o[7:0]`. A write of 0xF0 returns to read-array mode, and other writes are ignored.
- R14: A read updates `rdata_o` on the clock edge that samples `re_i`, and `rdata_o` holds while `re_i` is low. With `big_end_i` low, the byte at `addr_i` lands in `rdata_o[7:0]` and the next bytes in the next lanes up. With `big_end_i` high, the byte at `addr_i` lands in the most significant used lane (bits [15:8] for 2 bytes, [31:24] for 4). Unused lanes are zero. Program data follows the same lane mapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address, wraps modulo array size |
| wdata_i | input | 32 | Write data; command byte in bits [7:0] |
| size_i | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| big_end_i | input | 1 | 1 = lowest address in most significant lane |
| we_i | input | 1 | Bus write strobe |
| re_i | input | 1 | Bus read strobe |
| wp_i | input | 1 | Read-only: array contents frozen |
| rdata_o | output | 32 | Registered read data or status |
| busy_o | output | 1 | Program or erase in progress |

## Verification
The bench aims at near-miss sequences: right data at the wrong unlock address, a missing second unlock pair, and a chip-erase opcode at the wrong offset. A sequencer that checked only data or skipped a step would then program or erase bytes that must still read 0xFF or their old value. It measures busy time to the exact cycle for both erase kinds, so an off-by-one counter or a swapped length shows up. It also slips a complete program sequence in during an erase, which catches a design that still listens while busy. Multi-byte accesses that cross the top of the array, and both byte orders, catch address wrap and lane swap errors. Program data with bit 7 set and clear catches an inverted status bit.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_CMD, ST_PROG, ST_EU0, ST_EU1, ST_ECMD, ST_BUSY, ST_QUERY
  } seq_st_e;

  localparam logic [7:0] K_UNLK0 = 8'hAA;
  localparam logic [7:0] K_UNLK1 = 8'h55;
  localparam logic [7:0] K_PROG  = 8'hA0;
  localparam logic [7:0] K_ERSU  = 8'h80;
  localparam logic [7:0] K_CHIP  = 8'h10;
  localparam logic [7:0] K_SECT  = 8'h30;
  localparam logic [7:0] K_QRY   = 8'h98;
  localparam logic [7:0] K_EXIT  = 8'hF0;

  function automatic logic [2:0] bytes_of(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // lane holding the k-th byte from the access address
  function automatic logic [1:0] lane_of(input logic [1:0] k, input logic [2:0] nb,
                                         input logic be);
    logic [2:0] t;
    t = be ? (nb - 3'd1 - {1'b0, k}) : {1'b0, k};
    return t[1:0];
  endfunction

endpackage

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_seq_pkg::*;
#(
  parameter int SECT_W         = 8,
  parameter int UNLOCK_A       = 'h55,
  parameter int UNLOCK_B       = 'hAA,
  parameter int QUERY_OFS      = 'h55,
  parameter int CNT_W          = 9,
  parameter int PROG_CYC       = 4,
  parameter int SECT_ERASE_CYC = 40,
  parameter int CHIP_ERASE_CYC = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SECT_W-1:0] ofs_i,
  input  logic [7:0]        cmd_i,
  input  logic              done_i,
  output seq_st_e           state_o,
  output logic [7:0]        status_o,
  output logic              prog_go_o,
  output logic              chip_go_o,
  output logic              sect_go_o,
  output logic              tmr_load_o,
  output logic [CNT_W-1:0]  tmr_len_o
);
  localparam logic [SECT_W-1:0] OFS_A = SECT_W'(UNLOCK_A);
  localparam logic [SECT_W-1:0] OFS_B = SECT_W'(UNLOCK_B);
  localparam logic [SECT_W-1:0] OFS_Q = SECT_W'(QUERY_OFS);

  seq_st_e    st_q, st_d;
  logic [7:0] status_q, status_d;
  logic       at_a, at_b;

  assign at_a = (ofs_i == OFS_A);
  assign at_b = (ofs_i == OFS_B);

  always_comb begin
    st_d       = st_q;
    status_d   = status_q;
    prog_go_o  = 1'b0;
    chip_go_o  = 1'b0;
    sect_go_o  = 1'b0;
    tmr_load_o = 1'b0;
    tmr_len_o  = '0;
    unique case (st_q)
      ST_READ: if (we_i) begin
        if (ofs_i == OFS_Q && cmd_i == K_QRY) st_d = ST_QUERY;
        else if (at_a && cmd_i == K_UNLK0)    st_d = ST_UNL1;
      end
      ST_UNL1: if (we_i) st_d = (at_b && cmd_i == K_UNLK1) ? ST_CMD : ST_READ;
      ST_CMD: if (we_i) begin
        if (at_a && cmd_i == K_PROG)      st_d = ST_PROG;
        else if (at_a && cmd_i == K_ERSU) st_d = ST_EU0;
        else                              st_d = ST_READ;
      end
      ST_PROG: if (we_i) begin
        prog_go_o  = 1'b1;
        tmr_load_o = 1'b1;
        tmr_len_o  = CNT_W'(PROG_CYC);
        status_d   = {~cmd_i[7], 7'b0};
        st_d       = ST_BUSY;
      end
      ST_EU0: if (we_i) st_d = (at_a && cmd_i == K_UNLK0) ? ST_EU1 : ST_READ;
      ST_EU1: if (we_i) st_d = (at_b && cmd_i == K_UNLK1) ? ST_ECMD : ST_READ;
      ST_ECMD: if (we_i) begin
        if (at_a && cmd_i == K_CHIP) begin
          chip_go_o  = 1'b1;
          tmr_load_o = 1'b1;
          tmr_len_o  = CNT_W'(CHIP_ERASE_CYC);
          status_d   = 8'h00;
          st_d       = ST_BUSY;
        end else if (cmd_i == K_SECT) begin
          sect_go_o  = 1'b1;
          tmr_load_o = 1'b1;
          tmr_len_o  = CNT_W'(SECT_ERASE_CYC);
          status_d   = 8'h00;
          st_d       = ST_BUSY;
        end else begin
          st_d = ST_READ;
        end
      end
      ST_BUSY:  if (done_i) st_d = ST_READ;  // bus writes ignored
      ST_QUERY: if (we_i && cmd_i == K_EXIT) st_d = ST_READ;
      default:  st_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_READ;
      status_q <= 8'h00;
    end else begin
      st_q     <= st_d;
      status_q <= status_d;
    end
  end

  assign state_o  = st_q;
  assign status_o = status_q;
endmodule

// File: rtl/nor_array.sv
module nor_array
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SECT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [1:0]        size_i,
  input  logic              be_i,
  input  logic              wp_i,
  input  logic              prog_go_i,
  input  logic              chip_go_i,
  input  logic              sect_go_i,
  output logic [31:0]       rd_o
);
  localparam int CHIP  = 1 << ADDR_W;
  localparam int SID_W = ADDR_W - SECT_W;

  logic [7:0]        mem [CHIP];
  logic [2:0]        nb;
  logic [ADDR_W-1:0] baddr [4];
  logic [7:0]        wbyte [4];
  logic [1:0]        lane  [4];
  logic [3:0]        en;
  logic [SID_W-1:0]  sid;

  assign nb  = bytes_of(size_i);
  assign sid = addr_i[ADDR_W-1:SECT_W];

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign baddr[k] = addr_i + ADDR_W'(k);
    assign lane[k]  = lane_of(2'(k), nb, be_i);
    assign en[k]    = (3'(k) < nb);
    assign wbyte[k] = wdata_i[8*lane[k] +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CHIP; i++) mem[i] <= 8'hFF;
    end else if (!wp_i) begin
      if (chip_go_i) begin
        for (int i = 0; i < CHIP; i++) mem[i] <= 8'hFF;
      end else if (sect_go_i) begin
        for (int i = 0; i < CHIP; i++)
          if (ADDR_W'(i) >> SECT_W == ADDR_W'(sid)) mem[i] <= 8'hFF;
      end else if (prog_go_i) begin
        for (int k = 0; k < 4; k++)
          if (en[k]) mem[baddr[k]] <= mem[baddr[k]] & wbyte[k];
      end
    end
  end

  always_comb begin
    rd_o = '0;
    for (int k = 0; k < 4; k++)
      if (en[k]) rd_o[8*lane[k] +: 8] = mem[baddr[k]];
  end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W         = 10,
  parameter int SECT_W         = 8,
  parameter int UNLOCK_A       = 'h55,
  parameter int UNLOCK_B       = 'hAA,
  parameter int QUERY_OFS      = 'h55,
  parameter int PROG_CYC       = 4,
  parameter int SECT_ERASE_CYC = 40,
  parameter int CHIP_ERASE_CYC = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [1:0]        size_i,
  input  logic              big_end_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              wp_i,
  output logic [31:0]       rdata_o,
  output logic              busy_o
);
  localparam int MAX_CYC = (CHIP_ERASE_CYC > SECT_ERASE_CYC) ?
                           ((CHIP_ERASE_CYC > PROG_CYC) ? CHIP_ERASE_CYC : PROG_CYC) :
                           ((SECT_ERASE_CYC > PROG_CYC) ? SECT_ERASE_CYC : PROG_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_st_e           seq_st;
  logic [7:0]        status;
  logic              prog_go, chip_go, sect_go, tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_len;
  logic [31:0]       arr_rd;
  logic [SECT_W-1:0] ofs;
  logic [7:0]        qbyte;

  assign ofs = addr_i[SECT_W-1:0];

  nor_cmd_fsm #(
    .SECT_W(SECT_W), .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B), .QUERY_OFS(QUERY_OFS),
    .CNT_W(CNT_W), .PROG_CYC(PROG_CYC), .SECT_ERASE_CYC(SECT_ERASE_CYC),
    .CHIP_ERASE_CYC(CHIP_ERASE_CYC)
  ) u_fsm (
    .clk_i, .rst_ni, .we_i, .ofs_i(ofs), .cmd_i(wdata_i[7:0]), .done_i(tmr_done),
    .state_o(seq_st), .status_o(status), .prog_go_o(prog_go), .chip_go_o(chip_go),
    .sect_go_o(sect_go), .tmr_load_o(tmr_load), .tmr_len_o(tmr_len)
  );

  nor_busy_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .len_i(tmr_len), .busy_o(busy_o), .done_o(tmr_done)
  );

  nor_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_arr (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .size_i, .be_i(big_end_i), .wp_i,
    .prog_go_i(prog_go), .chip_go_i(chip_go), .sect_go_i(sect_go), .rd_o(arr_rd)
  );

  always_comb begin
    qbyte = 8'h00;
    if (ofs == SECT_W'('h10)) qbyte = 8'h51;
    if (ofs == SECT_W'('h11)) qbyte = 8'h52;
    if (ofs == SECT_W'('h12)) qbyte = 8'h59;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (re_i) begin
      case (seq_st)
        ST_BUSY:  rdata_o <= {24'b0, status};
        ST_QUERY: rdata_o <= {24'b0, qbyte};
        default:  rdata_o <= arr_rd;
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk
  import nor_seq_pkg::*;
#(
  parameter int CHIP_ERASE_CYC = 400
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        re_i,
  input logic        busy_i,
  input logic [31:0] rdata_i,
  input seq_st_e     state_i,
  input logic        prog_go_i,
  input logic        chip_go_i,
  input logic        sect_go_i
);
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_i) run_q <= run_q + 1;
    else             run_q <= '0;
  end

  assert_busy_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= 32'(CHIP_ERASE_CYC));

  assert_busy_end_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> state_i == ST_READ);

  assert_no_update_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !(prog_go_i || chip_go_i || sect_go_i));

  assert_status_width_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && busy_i) |=> rdata_i[31:8] == 24'b0);

  assert_rdata_hold_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_i));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.CHIP_ERASE_CYC(CHIP_ERASE_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .re_i(re_i), .busy_i(busy_o), .rdata_i(rdata_o),
  .state_i(seq_st), .prog_go_i(prog_go), .chip_go_i(chip_go), .sect_go_i(sect_go)
);

// File: tb/tb_nor_cmd_seq.sv
`timescale 1ns/1ps
module tb_nor_cmd_seq;
  localparam int PROG_N = 4;
  localparam int SECT_N = 40;
  localparam int CHIP_N = 400;

  localparam logic [1:0] WR = 2'd0, RD = 2'd1, ID = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  sz;
    logic        be;
    logic [9:0]  a;
    logic [31:0] d;
    logic [31:0] x;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 56;
  localparam vec_t VT [NV] = '{
    '{RD, 2'd2, 1'b0, 10'h100, 32'h0,        32'hFFFFFFFF, 4'd1},  // R1 erased
    '{WR, 2'd0, 1'b0, 10'h055, 32'hAA,       32'h0, 4'd5},
    '{WR, 2'd0, 1'b0, 10'h0AA, 32'h55,       32'h0, 4'd5},
    '{WR, 2'd0, 1'b0, 10'h055, 32'hA0,       32'h0, 4'd5},
    '{WR, 2'd2, 1'b0, 10'h100, 32'h12345678, 32'h0, 4'd5},
    '{RD, 2'd0, 1'b0, 10'h000, 32'h0,        32'h00000080, 4'd6},  // R6 bit7 clear
    '{ID, 2'd0, 1'b0, 10'h000, 32'd4,        32'h0, 4'd0},
    '{RD, 2'd2, 1'b0, 10'h100, 32'h0,        32'h12345678, 4'd5},
    '{RD, 2'd2, 1'b1, 10'h100, 32'h0,        32'h78563412, 4'd14}, // R14
    '{RD, 2'd1, 1'b1, 10'h102, 32'h0,        32'h00003412, 4'd14},
    '{RD, 2'd1, 1'b0, 10'h102, 32'h0,        32'h00001234, 4'd14},
    '{RD, 2'd0, 1'b1, 10'h101, 32'h0,        32'h00000056, 4'd14},
    '{WR, 2'd0, 1'b0, 10'h055, 32'hAA,       32'h0, 4'd5},
    '{WR, 2'd0, 1'b0, 10'h0AA, 32'h55,       32'h0, 4'd5},
    '{WR, 2'd0, 1'b0, 10'h055, 32'hA0,       32'h0, 4'd5},
    '{WR, 2'd2, 1'b0, 10'h100, 32'hFF00FF8F, 32'h0, 4'd5},
    '{RD, 2'd0, 1'b0, 10'h000, 32'h0,        32'h00000000, 4'd6},  // R6 bit7 set
    '{ID, 2'd0, 1'b0, 10'h000, 32'd4,        32'h0, 4'd0},
    '{RD, 2'd2, 1'b0, 10'h100, 32'h0,        32'h12005608, 4'd5},  // R5 AND
    '{WR, 2'd0, 1'b0, 10'h055, 32'hAA,       32'h0, 4'd5},
    '{WR, 2'd0, 1'b0, 10'h0AA, 32'h55,       32'h0, 4'd5},
    '{WR, 2'd0, 1'b0, 10'h055, 32'hA0,       32'h0, 4'd5},
    '{WR, 2'd1, 1'b0, 10'h3FF, 32'h1234,     32'h0, 4'd5},
    '{ID, 2'd0, 1'b0, 10'h000, 32'd5,        32'h0, 4'd0},
    '{RD, 2'd1, 1'b0, 10'h3FF, 32'h0,        32'h00001234, 4'd5},  // R5 wrap
    '{RD, 2'd0, 1'b0, 10'h000, 32'h0,        32'h00000012, 4'd5},
    '{WR, 2'd0, 1'b0, 10'h055, 32'hAA,       32'h0, 4'd14},
    '{WR, 2'd0, 1'b0, 10'h0AA, 32'h55,       32'h0, 4'd14},
    '{WR, 2'd0, 1'b0, 10'h055, 32'hA0,       32'h0, 4'd14},
    '{WR, 2'd1, 1'b1, 10'h200, 32'hA5C3,     32'h0, 4'd14},
    '{ID, 2'd0, 1'b0, 10'h000, 32'd5,        32'h0, 4'd0},
    '{RD, 2'd1, 1'b0, 10'h200, 32'h0,        32'h0000C3A5, 4'd14}, // R14 BE write
    '{WR, 2'd0, 1'b0, 10'h055, 32'hAB,       32'h0, 4'd2},         // R2 bad data
    '{WR, 2'd0, 1'b0, 10'h0AA, 32'h55,       32'h0, 4'd2},
    '{WR, 2'd0, 1'b0, 10'h055, 32'hA0,       32'h0, 4'd2},
    '{WR, 2'd0, 1'b0, 10'h210, 32'h00,       32'h0, 4'd2},
    '{ID, 2'd0, 1'b0, 10'h000, 32'd5,        32'h0, 4'd0},
    '{RD, 2'd0, 1'b0, 10'h210, 32'h0,        32'h000000FF, 4'd2},
    '{WR, 2'd0, 1'b0, 10'h055, 32'hAA,       32'h0, 4'd3},         // R3 bad addr
    '{WR, 2'd0, 1'b0, 10'h0AB, 32'h55,       32'h0, 4'd3},
    '{WR, 2'd0, 1'b0, 10'h055, 32'hA0,       32'h0, 4'd3},
    '{WR, 2'd0, 1'b0, 10'h211, 32'h00,       32'h0, 4'd3},
    '{ID, 2'd0, 1'b0, 10'h000, 32'd5,        32'h0, 4'd0},
    '{RD, 2'd0, 1'b0, 10'h211, 32'h0,        32'h000000FF, 4'd3},
    '{WR, 2'd0, 1'b0, 10'h055, 32'hAA,       32'h0, 4'd4},         // R4 bad addr
    '{WR, 2'd0, 1'b0, 10'h0AA, 32'h55,       32'h0, 4'd4},
    '{WR, 2'd0, 1'b0, 10'h056, 32'hA0,       32'h0, 4'd4},
    '{WR, 2'd0, 1'b0, 10'h212, 32'h00,       32'h0, 4'd4},
    '{ID, 2'd0, 1'b0, 10'h000, 32'd5,        32'h0, 4'd0},
    '{RD, 2'd0, 1'b0, 10'h212, 32'h0,        32'h000000FF, 4'd4},
    '{WR, 2'd0, 1'b0, 10'h055, 32'hAA,       32'h0, 4'd4},         // R4 bad command
    '{WR, 2'd0, 1'b0, 10'h0AA, 32'h55,       32'h0, 4'd4},
    '{WR, 2'd0, 1'b0, 10'h055, 32'h90,       32'h0, 4'd4},
    '{WR, 2'd0, 1'b0, 10'h213, 32'h00,       32'h0, 4'd4},
    '{ID, 2'd0, 1'b0, 10'h000, 32'd5,        32'h0, 4'd0},
    '{RD, 2'd0, 1'b0, 10'h213, 32'h0,        32'h000000FF, 4'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  size = '0;
  logic        big = 1'b0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic        wp = 1'b0;
  logic [31:0] rdata;
  logic        busy;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int c0;
  logic [31:0] v;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nor_cmd_seq #(
    .PROG_CYC(PROG_N), .SECT_ERASE_CYC(SECT_N), .CHIP_ERASE_CYC(CHIP_N)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .size_i(size),
    .big_end_i(big), .we_i(we), .re_i(re), .wp_i(wp), .rdata_o(rdata), .busy_o(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic wr(input logic [9:0] a, input logic [31:0] d,
                    input logic [1:0] sz = 2'd0, input logic b = 1'b0);
    we = 1'b1; addr = a; wdata = d; size = sz; big = b;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] r,
                    input logic [1:0] sz = 2'd0, input logic b = 1'b0);
    re = 1'b1; addr = a; size = sz; big = b;
    @(negedge clk);
    re = 1'b0;
    r = rdata;
  endtask

  task automatic unlock2();
    wr(10'h055, 32'hAA);
    wr(10'h0AA, 32'h55);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 busy", 32'(busy), 32'h0);
    check("R1 rdata", rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VT[i].op)
        WR: wr(VT[i].a, VT[i].d, VT[i].sz, VT[i].be);
        RD: begin
          rd(VT[i].a, v, VT[i].sz, VT[i].be);
          check($sformatf("R%0d vec%0d", VT[i].rq, i), v, VT[i].x);
        end
        default: repeat (int'(VT[i].d)) @(negedge clk);
      endcase
    end

    // R7: erase opcode without a complete second unlock pair
    unlock2(); wr(10'h055, 32'h80); wr(10'h055, 32'hAA); wr(10'h0AB, 32'h55);
    wr(10'h105, 32'h30);
    check("R7 no busy bad pair", 32'(busy), 32'h0);
    unlock2(); wr(10'h055, 32'h80); wr(10'h105, 32'h30);
    check("R7 no busy no pair", 32'(busy), 32'h0);
    rd(10'h100, v, 2'd2); check("R7 data kept", v, 32'h12005608);

    // R8: chip erase at wrong offset
    unlock2(); wr(10'h055, 32'h80); unlock2(); wr(10'h056, 32'h10);
    check("R8 no busy", 32'(busy), 32'h0);
    rd(10'h000, v); check("R8 data kept", v, 32'h12);

    // R9/R10/R11: sector erase, writes during busy
    unlock2(); wr(10'h055, 32'h80); unlock2(); wr(10'h105, 32'h30);
    c0 = cyc;
    check("R10 sect busy rise", 32'(busy), 32'h1);
    rd(10'h100, v, 2'd2); check("R10 erase status", v, 32'h0);
    unlock2(); wr(10'h055, 32'hA0); wr(10'h000, 32'h00);  // R11 ignored
    while (cyc < c0 + SECT_N - 1) @(negedge clk);
    check("R10 sect busy last", 32'(busy), 32'h1);
    @(negedge clk);
    check("R10 sect busy fall", 32'(busy), 32'h0);
    rd(10'h100, v, 2'd2); check("R9 sector ff", v, 32'hFFFFFFFF);
    rd(10'h1FF, v);       check("R9 sector end", v, 32'hFF);
    rd(10'h000, v);       check("R11 write ignored", v, 32'h12);
    rd(10'h3FF, v);       check("R9 other sector", v, 32'h34);
    rd(10'h200, v, 2'd1); check("R9 other sector 2", v, 32'hC3A5);

    // R12: read-only input
    wp = 1'b1;
    unlock2(); wr(10'h055, 32'hA0); wr(10'h010, 32'h00);
    check("R12 prog busy", 32'(busy), 32'h1);
    rd(10'h010, v); check("R12 prog status", v, 32'h80);
    repeat (PROG_N) @(negedge clk);
    rd(10'h010, v); check("R12 prog blocked", v, 32'hFF);
    unlock2(); wr(10'h055, 32'h80); unlock2(); wr(10'h200, 32'h30);
    c0 = cyc;
    check("R12 erase busy", 32'(busy), 32'h1);
    while (cyc < c0 + SECT_N) @(negedge clk);
    check("R12 erase busy fall", 32'(busy), 32'h0);
    rd(10'h200, v, 2'd1); check("R12 erase blocked", v, 32'hC3A5);
    wp = 1'b0;

    // R10/R8: chip erase timing and result
    unlock2(); wr(10'h055, 32'h80); unlock2(); wr(10'h055, 32'h10);
    c0 = cyc;
    check("R10 chip busy rise", 32'(busy), 32'h1);
    while (cyc < c0 + CHIP_N - 1) @(negedge clk);
    check("R10 chip busy last", 32'(busy), 32'h1);
    @(negedge clk);
    check("R10 chip busy fall", 32'(busy), 32'h0);
    rd(10'h000, v);       check("R8 chip ff lo", v, 32'hFF);
    rd(10'h200, v, 2'd2); check("R8 chip ff mid", v, 32'hFFFFFFFF);
    rd(10'h3FF, v);       check("R8 chip ff hi", v, 32'hFF);
    unlock2(); wr(10'h055, 32'hA0); wr(10'h300, 32'h3C);
    repeat (PROG_N) @(negedge clk);
    rd(10'h300, v); check("R10 back to read mode", v, 32'h3C);

    // R13: query mode
    wr(10'h055, 32'h98);
    rd(10'h010, v); check("R13 q0", v, 32'h51);
    rd(10'h011, v); check("R13 q1", v, 32'h52);
    rd(10'h112, v); check("R13 q2 other sector", v, 32'h59);
    rd(10'h020, v); check("R13 q other", v, 32'h00);
    wr(10'h010, 32'h00);
    rd(10'h010, v); check("R13 write ignored", v, 32'h51);
    wr(10'h000, 32'hF0);
    rd(10'h010, v); check("R13 exit", v, 32'hFF);

    summary();
  end
endmodule